// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds a bank of interrupt sources and decides when each one is offered to an interrupt presenter. A build-time map fixes every source as either level-sensitive or message type. Each source keeps a target server, a priority, a saved priority and four status flags: asserted, sent, rejected and held-while-masked. A priority of all ones masks the source. Message sources raise one trigger pulse per interrupt. Level sources follow a wire.

The presenter answers a presentation one cycle later, or at any later time, through a reject strobe or an end-of-interrupt strobe. Either strobe carries the global source number. The presenter can also ask for a resend, which makes the bank re-offer whatever it is still holding back. All wanted presentations go through a round-robin picker. The bank issues at most one presentation per cycle, and it carries the server, the global source number and the priority.

Configuration uses one write port. A write names a source index and updates that source's server, priority and saved priority. The write can release a message interrupt that arrived while the source was masked, or re-offer a level source.

Top module: `irq_source_bank`

## Requirements
- R1: A priority of 0xFF masks a source, so a masked source is never presented. Every presentation carries a priority other than 0xFF.
- R2: Reset sets every source's priority and saved priority to 0xFF and clears all status flags, including held-while-masked. The level or message kind of each source is unchanged by reset. No presentation is made during reset or in the first cycle after it.
- R3: A trigger pulse on a message source presents that source if it is unmasked. If it is masked, the pulse sets held-while-masked and nothing is presented.
- R4: A level source records its input in the asserted flag. The source is presented only when it is unmasked, asserted and not yet sent, and presenting it sets sent. This check runs on a rising input, on a configuration write to the source and on a resend.
- R5: Rejecting a message source sets its rejected flag. Rejecting a level source clears its sent flag. Neither strobe presents anything by itself.
- R6: An end-of-interrupt strobe clears the sent flag of a level source. It has no effect on a message source and presents nothing by itself.
- R7: A resend clears the rejected flag of every rejected message source and re-presents each such source that is unmasked. The same resend runs the R4 check on every level source.
- R8: A configuration write stores the server, priority and saved priority of the source it names. A message source with held-while-masked set and a new priority other than 0xFF then clears that flag and is presented. A level source is checked again under R4.
- R9: The global source number equals BASE plus the local index. BASE is 0x1000 by default. Sources 0 to 7 are message type and sources 8 to 15 are level type by default.
- R10: At most one presentation is issued per cycle. Sources waiting at the same time are served in round-robin order, one per cycle.
- R11: A reject or end-of-interrupt strobe whose number lies outside BASE to BASE+NUM_SRC-1 changes no source, even when its low bits match a local index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | NUM_SRC | Per-source trigger pulses, used by message sources |
| lvl_in | input | NUM_SRC | Per-source level lines, used by level sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source being written |
| cfg_server | input | SRV_W | New target server |
| cfg_pri | input | PRI_W | New priority (0xFF masks the source) |
| cfg_saved | input | PRI_W | New saved priority |
| rej_valid | input | 1 | Reject strobe from the presenter |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number named by the end-of-interrupt |
| resend_req | input | 1 | Resend request |
| pres_valid | output | 1 | A presentation is issued this cycle |
| pres_server | output | SRV_W | Target server of the presentation |
| pres_num | output | NUM_W | Global source number of the presentation |
| pres_pri | output | PRI_W | Priority of the presentation |

## Verification
The main patterns are full message cycles and full level cycles. A message cycle is trigger while masked, unmask, trigger, reject, end-of-interrupt, resend. This shows that a held interrupt is released and that the rejected flag drives the retry. A level cycle runs a masked rise, an unmask, a repeated resend, end-of-interrupt, reject, deassert and re-rise. This shows that the sent flag alone blocks a second offer and that only a rising edge or an explicit re-check presents again.

Out-of-range strobes whose low bits alias a live source are followed by a resend. That resend exposes any flag the strobe wrongly changed. Two triggers in the same cycle separate serialised service from a lost request. A reset taken while an interrupt is held masked shows that the flags are cleared while the level or message kind is kept.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;

  // Per-source status flags
  typedef struct packed {
    logic asserted;   // level input last seen high
    logic sent;       // level source offered and not yet retired
    logic rejected;   // message source bounced by the presenter
    logic held;       // message arrived while masked
  } src_stat_t;

  localparam int STAT_W = $bits(src_stat_t);

endpackage

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
  import irqsrc_pkg::*;
#(
  parameter int SRV_W    = 8,
  parameter int PRI_W    = 8,
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             lvl_i,
  input  logic             cfg_hit_i,
  input  logic [SRV_W-1:0] cfg_srv_i,
  input  logic [PRI_W-1:0] cfg_pri_i,
  input  logic [PRI_W-1:0] cfg_saved_i,
  input  logic             rej_hit_i,
  input  logic             eoi_hit_i,
  input  logic             resend_i,
  input  logic             grant_i,
  output logic             want_o,
  output logic [SRV_W-1:0] srv_o,
  output logic [PRI_W-1:0] pri_o,
  output logic [PRI_W-1:0] saved_o,
  output src_stat_t        stat_o
);

  localparam logic [PRI_W-1:0] MASK_PRI = '1;

  logic [SRV_W-1:0] srv_q, srv_d;
  logic [PRI_W-1:0] pri_q, pri_d;
  logic [PRI_W-1:0] saved_q, saved_d;
  src_stat_t        stat_q, stat_d;
  logic             queued_q, queued_d;
  logic             level_eval;

  always_comb begin
    srv_d      = srv_q;
    pri_d      = pri_q;
    saved_d    = saved_q;
    stat_d     = stat_q;
    queued_d   = queued_q & ~grant_i;
    level_eval = 1'b0;
    if (cfg_hit_i) begin
      srv_d   = cfg_srv_i;
      pri_d   = cfg_pri_i;
      saved_d = cfg_saved_i;
    end
    if (IS_LEVEL) begin
      stat_d.asserted = lvl_i;
      if (rej_hit_i || eoi_hit_i) stat_d.sent = 1'b0;
      level_eval = (lvl_i & ~stat_q.asserted) | cfg_hit_i | resend_i;
      if (level_eval && (pri_d != MASK_PRI) && lvl_i && !stat_d.sent) begin
        stat_d.sent = 1'b1;
        queued_d    = 1'b1;
      end
    end else begin
      if (rej_hit_i) stat_d.rejected = 1'b1;
      if (trig_i) begin
        if (pri_d == MASK_PRI) stat_d.held = 1'b1;
        else                   queued_d    = 1'b1;
      end
      if (cfg_hit_i && stat_d.held && (cfg_pri_i != MASK_PRI)) begin
        stat_d.held = 1'b0;
        queued_d    = 1'b1;
      end
      if (resend_i && stat_d.rejected) begin
        stat_d.rejected = 1'b0;
        if (pri_d != MASK_PRI) queued_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srv_q    <= '0;
      pri_q    <= MASK_PRI;
      saved_q  <= MASK_PRI;
      stat_q   <= '0;
      queued_q <= 1'b0;
    end else begin
      srv_q    <= srv_d;
      pri_q    <= pri_d;
      saved_q  <= saved_d;
      stat_q   <= stat_d;
      queued_q <= queued_d;
    end
  end

  assign want_o  = queued_q && (pri_q != MASK_PRI);
  assign srv_o   = srv_q;
  assign pri_o   = pri_q;
  assign saved_o = saved_q;
  assign stat_o  = stat_q;

endmodule

// File: rtl/irqsrc_rr_arb.sv
module irqsrc_rr_arb #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic          gvalid_o,
  output logic [IW-1:0] gidx_o
);

  logic [IW-1:0] ptr_q;

  always_comb begin
    gvalid_o = 1'b0;
    gidx_o   = '0;
    for (int k = 0; k < N; k++) begin
      if (!gvalid_o && req_i[(int'(ptr_q) + k) % N]) begin
        gvalid_o = 1'b1;
        gidx_o   = IW'((int'(ptr_q) + k) % N);
      end
    end
    grant_o = gvalid_o ? (N'(1) << gidx_o) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (gvalid_o) ptr_q <= (int'(gidx_o) == N - 1) ? '0 : gidx_o + IW'(1);
  end

endmodule

// File: rtl/irq_source_bank.sv
module irq_source_bank
  import irqsrc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int SRV_W   = 8,
  parameter int PRI_W   = 8,
  parameter int NUM_W   = 16,
  parameter logic [NUM_W-1:0]   BASE      = 16'h1000,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 16'hFF00,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic [NUM_SRC-1:0] lvl_in,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [PRI_W-1:0]   cfg_pri,
  input  logic [PRI_W-1:0]   cfg_saved,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend_req,
  output logic               pres_valid,
  output logic [SRV_W-1:0]   pres_server,
  output logic [NUM_W-1:0]   pres_num,
  output logic [PRI_W-1:0]   pres_pri
);

  // Global number of a local index (R9)
  function automatic logic [NUM_W-1:0] glob_num(input logic [IDX_W-1:0] idx);
    return BASE + NUM_W'(idx);
  endfunction

  // Number falls inside this bank (R11)
  function automatic logic in_bank(input logic [NUM_W-1:0] n);
    return (n >= BASE) && ((n - BASE) < NUM_W'(NUM_SRC));
  endfunction

  function automatic logic [IDX_W-1:0] local_idx(input logic [NUM_W-1:0] n);
    return IDX_W'(n - BASE);
  endfunction

  // Internal events, named for the checker
  logic [NUM_SRC-1:0]         cfg_hit, rej_hit, eoi_hit, want_vec, grant_vec;
  logic [NUM_SRC-1:0]         sent_vec, rejected_vec;
  logic [NUM_SRC*STAT_W-1:0]  stat_flat;
  logic [NUM_SRC*PRI_W-1:0]   saved_flat;
  logic [SRV_W-1:0]           srv_a [NUM_SRC];
  logic [PRI_W-1:0]           pri_a [NUM_SRC];
  logic                       rej_ok, eoi_ok, gvalid;
  logic [IDX_W-1:0]           rej_li, eoi_li, gidx;

  assign rej_ok = rej_valid && in_bank(rej_num);
  assign eoi_ok = eoi_valid && in_bank(eoi_num);
  assign rej_li = local_idx(rej_num);
  assign eoi_li = local_idx(eoi_num);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    src_stat_t st;
    assign cfg_hit[i] = cfg_we && (int'(cfg_idx) == i);
    assign rej_hit[i] = rej_ok && (int'(rej_li) == i);
    assign eoi_hit[i] = eoi_ok && (int'(eoi_li) == i);

    irqsrc_slot #(
      .SRV_W   (SRV_W),
      .PRI_W   (PRI_W),
      .IS_LEVEL(LEVEL_MAP[i])
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (trig_in[i]),
      .lvl_i      (lvl_in[i]),
      .cfg_hit_i  (cfg_hit[i]),
      .cfg_srv_i  (cfg_server),
      .cfg_pri_i  (cfg_pri),
      .cfg_saved_i(cfg_saved),
      .rej_hit_i  (rej_hit[i]),
      .eoi_hit_i  (eoi_hit[i]),
      .resend_i   (resend_req),
      .grant_i    (grant_vec[i]),
      .want_o     (want_vec[i]),
      .srv_o      (srv_a[i]),
      .pri_o      (pri_a[i]),
      .saved_o    (saved_flat[i*PRI_W +: PRI_W]),
      .stat_o     (st)
    );

    assign stat_flat[i*STAT_W +: STAT_W] = st;
    assign sent_vec[i]     = st.sent;
    assign rejected_vec[i] = st.rejected;
  end

  irqsrc_rr_arb #(.N(NUM_SRC)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (want_vec),
    .grant_o (grant_vec),
    .gvalid_o(gvalid),
    .gidx_o  (gidx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_valid  <= 1'b0;
      pres_server <= '0;
      pres_num    <= '0;
      pres_pri    <= '0;
    end else begin
      pres_valid <= gvalid;
      if (gvalid) begin
        pres_server <= srv_a[gidx];
        pres_num    <= glob_num(gidx);
        pres_pri    <= pri_a[gidx];
      end
    end
  end

endmodule

// File: rtl/irq_source_bank_chk.sv
module irq_source_bank_chk #(
  parameter int NUM_SRC = 16,
  parameter int PRI_W   = 8,
  parameter int NUM_W   = 16,
  parameter int STAT_W  = 4,
  parameter logic [NUM_W-1:0]   BASE      = 16'h1000,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 16'hFF00,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      pres_valid,
  input logic [NUM_W-1:0]          pres_num,
  input logic [PRI_W-1:0]          pres_pri,
  input logic [NUM_SRC-1:0]        grant_vec,
  input logic [NUM_SRC-1:0]        rej_hit,
  input logic [NUM_SRC-1:0]        sent_vec,
  input logic [NUM_SRC-1:0]        rejected_vec,
  input logic [NUM_SRC*STAT_W-1:0] stat_flat,
  input logic [NUM_SRC*PRI_W-1:0]  saved_flat,
  input logic [NUM_SRC-1:0]        lvl_in,
  input logic                      resend_req,
  input logic                      cfg_we,
  input logic [IDX_W-1:0]          cfg_idx,
  input logic [PRI_W-1:0]          cfg_saved
);

  localparam logic [PRI_W-1:0] MASK_PRI = '1;

  assert_unmasked_pres_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> pres_pri != MASK_PRI);

  assert_reset_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pres_valid && stat_flat == '0));

  assert_msg_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rej_hit & ~LEVEL_MAP) != '0 && !resend_req) |=>
      ((rejected_vec & $past(rej_hit & ~LEVEL_MAP)) == $past(rej_hit & ~LEVEL_MAP)));

  assert_lvl_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rej_hit & LEVEL_MAP) != '0 && !resend_req && !cfg_we && $stable(lvl_in)) |=>
      ((sent_vec & $past(rej_hit & LEVEL_MAP)) == '0));

  assert_saved_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_idx) < NUM_SRC) |=>
      saved_flat[$past(cfg_idx)*PRI_W +: PRI_W] == $past(cfg_saved));

  assert_num_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (pres_num >= BASE && (pres_num - BASE) < NUM_W'(NUM_SRC)));

  assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

endmodule

bind irq_source_bank irq_source_bank_chk #(
  .NUM_SRC  (NUM_SRC),
  .PRI_W    (PRI_W),
  .NUM_W    (NUM_W),
  .STAT_W   (irqsrc_pkg::STAT_W),
  .BASE     (BASE),
  .LEVEL_MAP(LEVEL_MAP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pres_valid  (pres_valid),
  .pres_num    (pres_num),
  .pres_pri    (pres_pri),
  .grant_vec   (grant_vec),
  .rej_hit     (rej_hit),
  .sent_vec    (sent_vec),
  .rejected_vec(rejected_vec),
  .stat_flat   (stat_flat),
  .saved_flat  (saved_flat),
  .lvl_in      (lvl_in),
  .resend_req  (resend_req),
  .cfg_we      (cfg_we),
  .cfg_idx     (cfg_idx),
  .cfg_saved   (cfg_saved)
);

// File: tb/sim_irq_source_bank.sv
module sim_irq_source_bank;

  localparam int NS = 16;

  localparam logic [3:0] OP_TRIG = 4'd1;
  localparam logic [3:0] OP_CFG  = 4'd2;
  localparam logic [3:0] OP_REJ  = 4'd3;
  localparam logic [3:0] OP_EOI  = 4'd4;
  localparam logic [3:0] OP_RSND = 4'd5;
  localparam logic [3:0] OP_LUP  = 4'd6;
  localparam logic [3:0] OP_LDN  = 4'd7;

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] arg;   // local index, or global number for reject/EOI
    logic [7:0]  srv;
    logic [7:0]  pri;
    logic [3:0]  cnt;   // expected presentations
    logic [15:0] enum_; // expected global number
    logic [7:0]  epri;
    logic [7:0]  esrv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  // Source 2 is message type, source 9 is level type (R9 default map)
  localparam vec_t TBL [NV] = '{
    '{OP_TRIG, 16'd2,      8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd3},  // R3 masked -> held
    '{OP_CFG,  16'd2,      8'd5, 8'd4,   4'd1, 16'h1002, 8'd4, 8'd5, 8'd8},  // R8 release held
    '{OP_TRIG, 16'd2,      8'd0, 8'd0,   4'd1, 16'h1002, 8'd4, 8'd5, 8'd3},  // R3
    '{OP_REJ,  16'h1002,   8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd5},  // R5
    '{OP_EOI,  16'h1002,   8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd6},  // R6
    '{OP_RSND, 16'd0,      8'd0, 8'd0,   4'd1, 16'h1002, 8'd4, 8'd5, 8'd7},  // R7
    '{OP_RSND, 16'd0,      8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd7},  // R7
    '{OP_REJ,  16'h1202,   8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd11}, // R11
    '{OP_RSND, 16'd0,      8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd11}, // R11
    '{OP_LUP,  16'd9,      8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd4},  // R4 masked
    '{OP_CFG,  16'd9,      8'd3, 8'd2,   4'd1, 16'h1009, 8'd2, 8'd3, 8'd8},  // R8 level
    '{OP_RSND, 16'd0,      8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd4},  // R4 sent blocks
    '{OP_EOI,  16'h1009,   8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd6},  // R6
    '{OP_RSND, 16'd0,      8'd0, 8'd0,   4'd1, 16'h1009, 8'd2, 8'd3, 8'd6},  // R6 sent cleared
    '{OP_EOI,  16'h1019,   8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd11}, // R11
    '{OP_RSND, 16'd0,      8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd11}, // R11
    '{OP_REJ,  16'h1009,   8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd5},  // R5
    '{OP_RSND, 16'd0,      8'd0, 8'd0,   4'd1, 16'h1009, 8'd2, 8'd3, 8'd5},  // R5
    '{OP_LDN,  16'd9,      8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd4},  // R4
    '{OP_EOI,  16'h1009,   8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd6},  // R6
    '{OP_RSND, 16'd0,      8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd4},  // R4 not asserted
    '{OP_LUP,  16'd9,      8'd0, 8'd0,   4'd1, 16'h1009, 8'd2, 8'd3, 8'd4},  // R4 rising edge
    '{OP_CFG,  16'd2,      8'd5, 8'hFF,  4'd0, 16'h0,    8'd0, 8'd0, 8'd1},  // R1
    '{OP_TRIG, 16'd2,      8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd1},  // R1
    '{OP_CFG,  16'd2,      8'd7, 8'd6,   4'd1, 16'h1002, 8'd6, 8'd7, 8'd8},  // R8
    '{OP_EOI,  16'h1009,   8'd0, 8'd0,   4'd0, 16'h0,    8'd0, 8'd0, 8'd6},  // R6
    '{OP_CFG,  16'd9,      8'd3, 8'd1,   4'd1, 16'h1009, 8'd1, 8'd3, 8'd8}   // R8 level re-check
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] trig_in = '0, lvl_in = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [7:0]    cfg_server = '0, cfg_pri = '0, cfg_saved = '0;
  logic          rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0;
  logic [15:0]   rej_num = '0, eoi_num = '0;
  logic          pres_valid;
  logic [7:0]    pres_server, pres_pri;
  logic [15:0]   pres_num;

  int n_chk = 0, n_err = 0;
  int cnt;
  logic [15:0] last_num;
  logic [7:0]  last_pri, last_srv;
  logic [NS-1:0] seen;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_source_bank u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .lvl_in(lvl_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_pri(cfg_pri), .cfg_saved(cfg_saved),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req),
    .pres_valid(pres_valid), .pres_server(pres_server),
    .pres_num(pres_num), .pres_pri(pres_pri)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [15:0] arg,
                       input logic [7:0] srv, input logic [7:0] pri);
    @(negedge clk);
    case (op)
      OP_TRIG: trig_in[arg[3:0]] = 1'b1;
      OP_CFG:  begin cfg_we = 1'b1; cfg_idx = arg[3:0]; cfg_server = srv;
                     cfg_pri = pri; cfg_saved = pri ^ 8'h5A; end
      OP_REJ:  begin rej_valid = 1'b1; rej_num = arg; end
      OP_EOI:  begin eoi_valid = 1'b1; eoi_num = arg; end
      OP_RSND: resend_req = 1'b1;
      OP_LUP:  lvl_in[arg[3:0]] = 1'b1;
      OP_LDN:  lvl_in[arg[3:0]] = 1'b0;
      default: ;
    endcase
    @(negedge clk);
    trig_in = '0; cfg_we = 1'b0; rej_valid = 1'b0;
    eoi_valid = 1'b0; resend_req = 1'b0;
  endtask

  task automatic watch();
    cnt = 0; seen = '0;
    repeat (6) begin
      @(negedge clk);
      if (pres_valid) begin
        cnt++;
        last_num = pres_num; last_pri = pres_pri; last_srv = pres_server;
        if (pres_num >= 16'h1000 && pres_num < 16'h1010) seen[pres_num[3:0]] = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pres_valid == 1'b0, "R2", "pres_valid in reset", pres_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pres_valid == 1'b0, "R2", "pres_valid after reset", pres_valid, 0);

    for (int v = 0; v < NV; v++) begin
      do_op(TBL[v].op, TBL[v].arg, TBL[v].srv, TBL[v].pri);
      watch();
      check(cnt == int'(TBL[v].cnt), $sformatf("R%0d row%0d", TBL[v].req, v),
            "count", cnt, TBL[v].cnt);
      if (TBL[v].cnt != 0 && cnt != 0) begin
        check(last_num == TBL[v].enum_, $sformatf("R%0d row%0d", TBL[v].req, v),
              "number (R9)", last_num, TBL[v].enum_);
        check(last_pri == TBL[v].epri, $sformatf("R%0d row%0d", TBL[v].req, v),
              "priority", last_pri, TBL[v].epri);
        check(last_srv == TBL[v].esrv, $sformatf("R%0d row%0d", TBL[v].req, v),
              "server", last_srv, TBL[v].esrv);
      end
    end

    // R10: two message sources triggered in the same cycle
    do_op(OP_CFG, 16'd4, 8'd1, 8'd3); watch();
    check(cnt == 0, "R10", "cfg src4 count", cnt, 0);
    do_op(OP_CFG, 16'd5, 8'd1, 8'd3); watch();
    check(cnt == 0, "R10", "cfg src5 count", cnt, 0);
    @(negedge clk);
    trig_in[4] = 1'b1; trig_in[5] = 1'b1;
    @(negedge clk);
    trig_in = '0;
    watch();
    check(cnt == 2, "R10", "two presentations", cnt, 2);
    check(seen[4] && seen[5], "R10", "both sources served", seen, 16'h0030);

    // R2: reset while a message is held masked; level kind survives reset
    do_op(OP_CFG, 16'd2, 8'd5, 8'hFF); watch();
    do_op(OP_TRIG, 16'd2, 8'd0, 8'd0); watch();
    check(cnt == 0, "R2", "masked trigger before reset", cnt, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pres_valid == 1'b0, "R2", "pres_valid in second reset", pres_valid, 0);
    rst_n = 1'b1;
    do_op(OP_CFG, 16'd2, 8'd5, 8'd4); watch();
    check(cnt == 0, "R2", "held flag cleared by reset", cnt, 0);
    do_op(OP_CFG, 16'd9, 8'd3, 8'd2); watch();
    check(cnt == 1, "R2", "level kind kept over reset", cnt, 1);
    check(last_num == 16'h1009, "R2", "level source number", last_num, 16'h1009);

    // R1: a source masked again after reset is not presented on trigger
    do_op(OP_TRIG, 16'd7, 8'd0, 8'd0); watch();
    check(cnt == 0, "R1", "reset-masked source trigger", cnt, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule